// File: doc/BRIEF.md
# USB Full-Speed Packet Field Parser

This block sits behind a full-speed line receiver that has already undone the NRZI coding and removed stuffed bits. It takes one destuffed bit per `bit_vld` cycle, plus an end-of-packet strobe and an abort strobe. From these it checks the leading synchronisation byte and classifies the packet identifier. It then splits out the fields that matter to a device-side consumer. Token packets give a device address and an endpoint. Start-of-frame packets give an 11-bit frame number. Data packets give a stream of payload bytes, and the trailing 16-bit CRC is never presented as payload. Handshakes give only their type.

Every packet that carried at least one bit closes with a one-cycle `done` strobe. The strobe carries a status code and the packet kind. Payload bytes are held back until sixteen further bits have arrived. The bits still held when end-of-packet comes are therefore the CRC, and they are discarded. An abort from the receiver, such as a bus reset or a stuffing violation, drops the packet silently, and the parser then waits for a new sync byte.

Top module: `usb_pkt_parser`

## Requirements
- R1: The first 8 bits of a packet, taken LSB first, must form the byte 0x80 (seven 0s, then a 1). Otherwise, or if end-of-packet arrives before 8 bits, `status` is 1 (sync error).
- R2: The 8 bits after sync, taken LSB first, form the PID byte. `kind` reports OUT(0xE1)=1, IN(0x69)=2, SOF(0xA5)=3, SETUP(0x2D)=4, DATA0(0xC3)=5, DATA1(0x4B)=6, ACK(0xD2)=7, NAK(0x5A)=8, STALL(0x1E)=9 and NYET(0x96)=10.
- R3: The PID is unknown when its upper nibble is not the complement of its lower nibble, when it is not one of the ten values in R2, or when end-of-packet arrives after a valid sync but before the PID is complete. An unknown PID gives `status` 2 (PID error) and `kind` 0, unless R1 already applies.
- R4: For OUT, IN and SETUP, `addr` holds the 7 bits after the PID and `endp` holds the next 4 bits, both LSB first.
- R5: For SOF, `frame` holds the 11 bits after the PID, LSB first.
- R6: For DATA0 and DATA1, each payload byte (LSB first) appears on `byte_data` with a one-cycle `byte_vld`. This happens in the cycle after the bit that completes 16 further bits following that byte. The final 16 bits are never emitted.
- R7: A handshake with no bits after the PID has `status` 0. Any extra bit gives `status` 3 (length error).
- R8: A token or SOF whose total length is not exactly 32 bits gives `status` 3.
- R9: A data packet gives `status` 3 when it has fewer than 16 bits after the PID or when its bit count is not a whole number of bytes.
- R10: `abort` discards the current packet with no `done`. The next packet is parsed from its sync byte.
- R11: `done` pulses for exactly one cycle, in the cycle after an `eop` that followed at least one bit. An `eop` that follows no bits produces nothing. Status priority is 1, then 2, then 3, then 0.
- R12: After reset, `done` and `byte_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A destuffed bit is present on `bit_in` |
| bit_in | input | 1 | Destuffed data bit |
| eop | input | 1 | End-of-packet strobe |
| abort | input | 1 | Bus reset or stuff error; discard packet |
| done | output | 1 | Packet finished; the fields below are valid |
| status | output | 2 | 0 ok, 1 sync error, 2 PID error, 3 length error |
| kind | output | 4 | Packet kind code per R2, 0 if unknown |
| addr | output | 7 | Token device address |
| endp | output | 4 | Token endpoint number |
| frame | output | 11 | SOF frame number |
| byte_vld | output | 1 | Payload byte strobe |
| byte_data | output | 8 | Payload byte |

## Verification
The bench builds the parser with its default 14-bit bit counter. That width covers data packets of over a thousand bytes, but the bench only needs short packets, so every sweep stays fast. The counter width lets the bench sweep all 256 PID bytes and all 256 sync bytes, every 7-bit address, and a stride through the 11-bit frame range. It also covers every residual bit count from 1 to 7 in data packets, every token length from 16 to 40 bits, and an abort in mid-packet.

// File: rtl/usb_pkt_parser.sv
module usb_pkt_parser #(
  parameter int CNT_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic        eop,
  input  logic        abort,
  output logic        done,
  output logic [1:0]  status,
  output logic [3:0]  kind,
  output logic [6:0]  addr,
  output logic [3:0]  endp,
  output logic [10:0] frame,
  output logic        byte_vld,
  output logic [7:0]  byte_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [7:0] SYNC_BYTE = 8'h80;

  logic [CNT_W-1:0] cnt;
  logic [23:0]      sh;
  logic             sync_ok;
  logic [3:0]       kind_q;

  wire [CNT_W-1:0] cnt_nx = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire [23:0]      sh_nx  = {bit_in, sh[23:1]};
  wire [7:0]       pid_nx = sh_nx[23:16];

  logic [3:0] kind_dec;
  always_comb begin
    kind_dec = 4'd0;
    if (pid_nx[7:4] == ~pid_nx[3:0]) begin
      case (pid_nx[3:0])
        4'h1: kind_dec = 4'd1;
        4'h9: kind_dec = 4'd2;
        4'h5: kind_dec = 4'd3;
        4'hD: kind_dec = 4'd4;
        4'h3: kind_dec = 4'd5;
        4'hB: kind_dec = 4'd6;
        4'h2: kind_dec = 4'd7;
        4'hA: kind_dec = 4'd8;
        4'hE: kind_dec = 4'd9;
        4'h6: kind_dec = 4'd10;
        default: kind_dec = 4'd0;
      endcase
    end
  end

  wire is_tok  = (kind_q >= 4'd1) && (kind_q <= 4'd4);
  wire is_data = (kind_q == 4'd5) || (kind_q == 4'd6);
  wire is_hs   = (kind_q >= 4'd7) && (kind_q <= 4'd10);
  wire pid_in  = (cnt >= CNT_W'(16));

  logic [1:0] st_eop;
  always_comb begin
    if (cnt < CNT_W'(8) || !sync_ok)                           st_eop = 2'd1;
    else if (!pid_in || kind_q == 4'd0)                        st_eop = 2'd2;
    else if (is_tok && cnt != CNT_W'(32))                      st_eop = 2'd3;
    else if (is_hs && cnt != CNT_W'(16))                       st_eop = 2'd3;
    else if (is_data && (cnt < CNT_W'(32) || cnt[2:0] != 3'd0)) st_eop = 2'd3;
    else                                                       st_eop = 2'd0;
  end

  wire emit = sync_ok && is_data && (cnt != CNT_MAX) &&
              (cnt_nx >= CNT_W'(40)) && (cnt_nx[2:0] == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      sync_ok   <= 1'b0;
      kind_q    <= 4'd0;
      done      <= 1'b0;
      status    <= 2'd0;
      kind      <= 4'd0;
      addr      <= '0;
      endp      <= '0;
      frame     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      done     <= 1'b0;
      byte_vld <= 1'b0;
      if (abort) begin
        cnt     <= '0;
        sync_ok <= 1'b0;
        kind_q  <= 4'd0;
      end else if (eop) begin
        if (cnt != '0) begin
          done   <= 1'b1;
          status <= st_eop;
          kind   <= pid_in ? kind_q : 4'd0;
          addr   <= sh[14:8];
          endp   <= sh[18:15];
          frame  <= sh[18:8];
        end
        cnt     <= '0;
        sync_ok <= 1'b0;
        kind_q  <= 4'd0;
      end else if (bit_vld) begin
        cnt <= cnt_nx;
        sh  <= sh_nx;
        if (cnt == CNT_W'(7))  sync_ok <= (pid_nx == SYNC_BYTE);
        if (cnt == CNT_W'(15)) kind_q  <= kind_dec;
        if (emit) begin
          byte_vld  <= 1'b1;
          byte_data <= sh_nx[7:0];
        end
      end
    end
  end

  p_byte_from_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (sync_ok && is_data));
  p_byte_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (cnt >= CNT_W'(40) && cnt[2:0] == 3'd0));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_eop_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !abort && cnt != '0) |=> done);
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!done && !byte_vld));
  p_tok_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !abort && sync_ok && pid_in && is_tok && cnt != CNT_W'(32)) |=> (status == 2'd3));
endmodule

// File: tb/usb_pkt_parser_tb.sv
module usb_pkt_parser_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_in = 1'b0, eop = 1'b0, abort = 1'b0;
  logic done, byte_vld;
  logic [1:0] status;
  logic [3:0] kind, endp;
  logic [6:0] addr;
  logic [10:0] frame;
  logic [7:0] byte_data;

  always #5 clk = ~clk;

  usb_pkt_parser dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .eop(eop),
    .abort(abort), .done(done), .status(status), .kind(kind), .addr(addr),
    .endp(endp), .frame(frame), .byte_vld(byte_vld), .byte_data(byte_data));

  integer tests = 0, fails = 0;
  integer mon_bytes = 0, mon_dones = 0;
  logic [7:0] got [0:4095];
  logic [1:0] d_st;
  logic [3:0] d_kind, d_ep;
  logic [6:0] d_addr;
  logic [10:0] d_frame;

  always @(negedge clk) begin
    if (byte_vld) begin
      got[mon_bytes % 4096] = byte_data;
      mon_bytes = mon_bytes + 1;
    end
    if (done) begin
      d_st = status; d_kind = kind; d_addr = addr; d_ep = endp; d_frame = frame;
      mon_dones = mon_dones + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_bits(input logic [31:0] v, input integer n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = v[i];
    end
  endtask

  task automatic end_pkt();
    @(negedge clk); bit_vld = 1'b0; eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic integer exp_kind(input logic [7:0] p);
    case (p)
      8'hE1: return 1;  8'h69: return 2;  8'hA5: return 3;  8'h2D: return 4;
      8'hC3: return 5;  8'h4B: return 6;  8'hD2: return 7;  8'h5A: return 8;
      8'h1E: return 9;  8'h96: return 10;
      default: return 0;
    endcase
  endfunction

  integer d0, b0;

  task automatic begin_pkt();
    d0 = mon_dones; b0 = mon_bytes;
  endtask

  task automatic expect_done(input string tag, input integer st, input integer k);
    chk(mon_dones == d0 + 1, {tag, " done count"}, mon_dones - d0, 1);
    chk(d_st == 2'(st), {tag, " status"}, d_st, st);
    chk(d_kind == 4'(k), {tag, " kind"}, d_kind, k);
  endtask

  initial begin
    #(10 * 190000);
    fails = fails + 1; tests = tests + 1;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && byte_vld == 1'b0, "R12 reset outputs", {done, byte_vld}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int p = 0; p < 256; p++) begin
      integer k, st, tail;
      k = exp_kind(8'(p));
      st = (k == 0) ? 2 : 0;
      tail = (k == 0 || k <= 6) ? 16 : 0;
      begin_pkt();
      put_bits(32'h80, 8); put_bits(32'(p), 8); put_bits(32'h5A3C, tail);
      end_pkt();
      expect_done("R2 R3 pid sweep", st, k);
    end

    for (int s = 0; s < 256; s++) begin
      begin_pkt();
      put_bits(32'(s), 8); put_bits(32'hD2, 8);
      end_pkt();
      expect_done("R1 sync sweep", (s == 8'h80) ? 0 : 1, 7);
    end

    begin_pkt(); put_bits(32'h0, 4); end_pkt();
    expect_done("R1 short sync", 1, 0);
    begin_pkt(); put_bits(32'h80, 8); put_bits(32'h1, 4); end_pkt();
    expect_done("R3 short pid", 2, 0);

    for (int a = 0; a < 128; a++) begin
      logic [7:0] pid;
      integer ep, k;
      ep = (a * 5) % 16;
      pid = (a % 3 == 0) ? 8'hE1 : (a % 3 == 1) ? 8'h69 : 8'h2D;
      k = exp_kind(pid);
      begin_pkt();
      put_bits(32'h80, 8); put_bits(32'(pid), 8);
      put_bits(32'(a), 7); put_bits(32'(ep), 4); put_bits(32'h15, 5);
      end_pkt();
      expect_done("R4 token", 0, k);
      chk(d_addr == 7'(a), "R4 addr", d_addr, a);
      chk(d_ep == 4'(ep), "R4 endp", d_ep, ep);
    end

    for (int f = 0; f < 2048 + 13; f += 13) begin
      integer fr;
      fr = (f > 2047) ? 2047 : f;
      begin_pkt();
      put_bits(32'h80, 8); put_bits(32'hA5, 8); put_bits(32'(fr), 11); put_bits(32'h0A, 5);
      end_pkt();
      expect_done("R5 sof", 0, 3);
      chk(d_frame == 11'(fr), "R5 frame", d_frame, fr);
    end

    for (int len = 0; len <= 12; len++) begin
      logic [7:0] pid;
      pid = (len % 2 == 0) ? 8'hC3 : 8'h4B;
      begin_pkt();
      put_bits(32'h80, 8); put_bits(32'(pid), 8);
      for (int i = 0; i < len; i++) put_bits(32'((len * 31 + i * 97 + 3) % 256), 8);
      put_bits(32'(16'hA5C3 ^ len), 16);
      end_pkt();
      expect_done("R6 data", 0, exp_kind(pid));
      chk(mon_bytes - b0 == len, "R6 byte count", mon_bytes - b0, len);
      for (int i = 0; i < len; i++)
        chk(got[(b0 + i) % 4096] == 8'((len * 31 + i * 97 + 3) % 256), "R6 byte value",
            got[(b0 + i) % 4096], (len * 31 + i * 97 + 3) % 256);
    end

    for (int x = 1; x <= 7; x++) begin
      begin_pkt();
      put_bits(32'h80, 8); put_bits(32'hC3, 8); put_bits(32'h11, 8);
      put_bits(32'hFFFF, 16); put_bits(32'h0, x);
      end_pkt();
      expect_done("R9 data odd bits", 3, 5);
    end
    begin_pkt(); put_bits(32'h80, 8); put_bits(32'h4B, 8); put_bits(32'h3, 8); end_pkt();
    expect_done("R9 data short", 3, 6);
    chk(mon_bytes == b0, "R9 no bytes short", mon_bytes - b0, 0);

    for (int n = 0; n <= 24; n++) begin
      if (n == 16) continue;
      begin_pkt();
      put_bits(32'h80, 8); put_bits((n % 2 == 0) ? 32'h69 : 32'hA5, 8); put_bits(32'h1234567, n);
      end_pkt();
      expect_done("R8 token length", 3, (n % 2 == 0) ? 2 : 3);
    end

    begin_pkt(); put_bits(32'h80, 8); put_bits(32'h5A, 8); end_pkt();
    expect_done("R7 handshake ok", 0, 8);
    begin_pkt(); put_bits(32'h80, 8); put_bits(32'h1E, 8); put_bits(32'hFF, 8); end_pkt();
    expect_done("R7 handshake extra", 3, 9);

    begin_pkt();
    put_bits(32'h80, 8); put_bits(32'hE1, 8); put_bits(32'h3, 6);
    @(negedge clk); bit_vld = 1'b0; abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    repeat (2) @(negedge clk);
    chk(mon_dones == d0, "R10 abort no done", mon_dones - d0, 0);
    begin_pkt();
    put_bits(32'h80, 8); put_bits(32'h69, 8); put_bits(32'h55, 7); put_bits(32'h9, 4); put_bits(32'h0, 5);
    end_pkt();
    expect_done("R10 after abort", 0, 2);
    chk(d_addr == 7'h55 && d_ep == 4'h9, "R10 fields", {d_addr, d_ep}, {7'h55, 4'h9});

    begin_pkt();
    @(negedge clk); eop = 1'b1;
    @(negedge clk); eop = 1'b0;
    repeat (2) @(negedge clk);
    chk(mon_dones == d0, "R11 empty eop", mon_dones - d0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule